// File: doc/BRIEF.md
# Phase-Leg Shoot-Through Interlock with Turn-On Delay

This block sits between a motor-control PWM generator and the gate drivers of a half-bridge inverter. For every phase leg it accepts a high-side and a low-side switch command, both already synchronous to the block clock and free of glitches. It produces the two gate enables for that leg. The parameter `NLEG` sets the number of legs, and its default of three covers a three-phase bridge.

The two switches of a leg must never conduct together. If both commands of a leg are high in the same cycle, both gates are switched off and held off. Once one of the two commands is withdrawn, the command still standing is honoured, but only after the normal turn-on delay. Every turn-on waits for a configurable number of clock cycles, `DEAD_CYC`, while every turn-off takes effect at the next clock edge. The command source therefore does not need to insert its own dead band.

A global inhibit input from the fault controller switches off every gate of every leg at once, and it also restarts every turn-on delay.

Top module: `pil_interlock`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it falls, every bit of `gate_hi` and `gate_lo` is 0. After reset, a gate turns on only after a full turn-on delay.
- R2: When, for `DEAD_CYC+1` consecutive clock edges, leg i samples `cmd_hi[i]`=1, `cmd_lo[i]`=0 and `inhibit`=0, then `gate_hi[i]` is 1 after the last of those edges. It stays 1 for as long as the condition holds.
- R3: R2 applies to the low side in the same way, with the roles of `cmd_lo[i]`/`gate_lo[i]` and `cmd_hi[i]` exchanged.
- R4: Turn-off has no delay. An edge that samples a gate's command at 0 leaves that gate at 0 after that edge.
- R5: An edge that samples both `cmd_hi[i]` and `cmd_lo[i]` at 1 leaves both gates of leg i at 0 after that edge.
- R6: When an overlap ends with one command still at 1, that side's gate turns on only after `DEAD_CYC+1` consecutive non-overlapping samples. The count starts at the first such sample.
- R7: A command pulse shorter than `DEAD_CYC+1` samples produces no gate pulse. The next rising command starts its delay count again from zero.
- R8: An edge that samples `inhibit`=1 leaves all gates at 0 after that edge. After `inhibit` is released, a held command needs a fresh full turn-on delay.
- R9: Legs are independent. The commands of one leg never change the gates of another leg.
- R10: `gate_hi[i]` and `gate_lo[i]` are never 1 in the same cycle, for any leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| inhibit | input | 1 | Fault inhibit, forces every gate off |
| cmd_hi | input | NLEG | High-side switch command per leg, active high |
| cmd_lo | input | NLEG | Low-side switch command per leg, active high |
| gate_hi | output | NLEG | Registered high-side gate enable per leg |
| gate_lo | output | NLEG | Registered low-side gate enable per leg |

## Verification
Two events can fall in the same cycle: the end of an overlap and the start of a turn-on delay for the command that is still high. The bench provokes this by raising both commands and then dropping only the low-side one while the high side stays up. It expects the high-side gate to stay off for the full delay, counted from the first sample without overlap, and never to come on straight away. The same kind of collision is provoked a second time by releasing `inhibit` while a command is held, and it is judged the same way.

// File: rtl/pil_pkg.sv
package pil_pkg;

  // One switch pair of a phase leg: high side and low side.
  typedef struct packed {
    logic hi;
    logic lo;
  } pil_pair_t;

  localparam int SIDE_HI = 1;
  localparam int SIDE_LO = 0;

endpackage

// File: rtl/pil_overlap.sv
// Combinational shoot-through filter: a side may request turn-on only when
// its own command is up, the opposite command is down and no inhibit is set.
module pil_overlap
  import pil_pkg::*;
(
  input  pil_pair_t cmd_i,
  input  logic      inhibit_i,
  output pil_pair_t req_o
);

  logic clash;

  always_comb begin
    clash    = cmd_i.hi & cmd_i.lo;
    req_o.hi = cmd_i.hi & ~clash & ~inhibit_i;
    req_o.lo = cmd_i.lo & ~clash & ~inhibit_i;
  end

endmodule

// File: rtl/pil_ondelay.sv
// Turn-on delay: the output rises after DEAD_CYC+1 consecutive sampled
// requests and falls at the first edge that samples the request low.
module pil_ondelay #(
  parameter int DEAD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic gate_o
);

  localparam int CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEAD_CYC);

  logic [CW-1:0] cnt_q;
  logic          expired;

  assign expired = (cnt_q == LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      gate_o <= 1'b0;
    end else begin
      if (!req_i) begin
        cnt_q <= '0;
      end else if (!expired) begin
        cnt_q <= cnt_q + 1'b1;
      end
      gate_o <= req_i & expired;
    end
  end

endmodule

// File: rtl/pil_leg.sv
// One phase leg: overlap filter followed by one delay stage per side.
module pil_leg
  import pil_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      inhibit,
  input  pil_pair_t cmd,
  output pil_pair_t gate
);

  pil_pair_t  req;
  logic [1:0] req_v;
  logic [1:0] gate_v;

  pil_overlap u_overlap (
    .cmd_i     (cmd),
    .inhibit_i (inhibit),
    .req_o     (req)
  );

  assign req_v = {req.hi, req.lo};

  for (genvar s = 0; s < 2; s++) begin : g_side
    pil_ondelay #(.DEAD_CYC(DEAD_CYC)) u_dly (
      .clk    (clk),
      .rst    (rst),
      .req_i  (req_v[s]),
      .gate_o (gate_v[s])
    );
  end

  assign gate.hi = gate_v[SIDE_HI];
  assign gate.lo = gate_v[SIDE_LO];

endmodule

// File: rtl/pil_interlock.sv
module pil_interlock
  import pil_pkg::*;
#(
  parameter int NLEG     = 3,
  parameter int DEAD_CYC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inhibit,
  input  logic [NLEG-1:0] cmd_hi,
  input  logic [NLEG-1:0] cmd_lo,
  output logic [NLEG-1:0] gate_hi,
  output logic [NLEG-1:0] gate_lo
);

  for (genvar i = 0; i < NLEG; i++) begin : g_leg
    pil_pair_t cmd_p;
    pil_pair_t gate_p;

    assign cmd_p.hi = cmd_hi[i];
    assign cmd_p.lo = cmd_lo[i];

    pil_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk     (clk),
      .rst     (rst),
      .inhibit (inhibit),
      .cmd     (cmd_p),
      .gate    (gate_p)
    );

    assign gate_hi[i] = gate_p.hi;
    assign gate_lo[i] = gate_p.lo;
  end

endmodule

// File: rtl/pil_checker.sv
module pil_checker #(
  parameter int NLEG = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            inhibit,
  input logic [NLEG-1:0] cmd_hi,
  input logic [NLEG-1:0] cmd_lo,
  input logic [NLEG-1:0] gate_hi,
  input logic [NLEG-1:0] gate_lo
);

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == '0); // R10

  AST_OFF_ON_DROP_HI: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (gate_hi & ~$past(cmd_hi)) == '0); // R4

  AST_OFF_ON_DROP_LO: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (gate_lo & ~$past(cmd_lo)) == '0); // R4

  AST_OVERLAP_OFF: assert property (@(posedge clk) disable iff (rst)
    (cmd_hi & cmd_lo) != '0 |=> ((gate_hi | gate_lo) & $past(cmd_hi & cmd_lo)) == '0); // R5

  AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> (gate_hi == '0) && (gate_lo == '0)); // R8

  for (genvar i = 0; i < NLEG; i++) begin : g_leg_chk
    AST_RISE_NEEDS_CLEAN_HI: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_hi[i]) |-> $past(cmd_hi[i]) && !$past(cmd_lo[i]) && !$past(inhibit)); // R2
    AST_RISE_NEEDS_CLEAN_LO: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_lo[i]) |-> $past(cmd_lo[i]) && !$past(cmd_hi[i]) && !$past(inhibit)); // R3
  end

endmodule

bind pil_interlock pil_checker #(.NLEG(NLEG)) u_pil_checker (
  .clk     (clk),
  .rst     (rst),
  .inhibit (inhibit),
  .cmd_hi  (cmd_hi),
  .cmd_lo  (cmd_lo),
  .gate_hi (gate_hi),
  .gate_lo (gate_lo)
);

// File: tb/pil_interlock_bench.sv
`timescale 1ns/1ps
module pil_interlock_bench;

  localparam int NLEG = 3;
  localparam int DT   = 2;   // turn-on after DT+1 clean samples
  localparam int NVEC = 26;

  logic            clk = 1'b0;
  logic            rst;
  logic            inhibit;
  logic [NLEG-1:0] cmd_hi;
  logic [NLEG-1:0] cmd_lo;
  logic [NLEG-1:0] gate_hi;
  logic [NLEG-1:0] gate_lo;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  pil_interlock #(.NLEG(NLEG), .DEAD_CYC(DT)) u_pil_interlock (
    .clk     (clk),
    .rst     (rst),
    .inhibit (inhibit),
    .cmd_hi  (cmd_hi),
    .cmd_lo  (cmd_lo),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo)
  );

  // Leg A vectors: {req, inhibit, cmd_hi, cmd_lo, exp gate_hi, exp gate_lo}
  // expectation holds after the edge that samples the inputs.
  localparam logic [8:0] VEC [NVEC] = '{
    {4'd4, 5'b00000},
    {4'd2, 5'b01000},  // R2 count 1
    {4'd2, 5'b01000},  // R2 count 2
    {4'd2, 5'b01010},  // R2 on
    {4'd2, 5'b01010},
    {4'd4, 5'b00000},  // R4 immediate off
    {4'd3, 5'b00100},  // R3
    {4'd3, 5'b00100},
    {4'd3, 5'b00101},  // R3 on
    {4'd5, 5'b01100},  // R5 overlap
    {4'd5, 5'b01100},
    {4'd6, 5'b01000},  // R6 overlap cleared, delay restarts
    {4'd6, 5'b01000},
    {4'd6, 5'b01010},  // R6 on
    {4'd4, 5'b00000},
    {4'd7, 5'b01000},  // R7 short pulse
    {4'd7, 5'b01000},
    {4'd7, 5'b00000},
    {4'd7, 5'b01000},  // R7 count restarts
    {4'd7, 5'b01000},
    {4'd7, 5'b01010},
    {4'd8, 5'b11000},  // R8 inhibit
    {4'd8, 5'b01000},
    {4'd8, 5'b01000},
    {4'd8, 5'b01010},  // R8 fresh delay
    {4'd4, 5'b00000}
  };

  task automatic check(input int req, input logic [NLEG-1:0] exp_hi,
                       input logic [NLEG-1:0] exp_lo);
    checks++;
    if (gate_hi !== exp_hi || gate_lo !== exp_lo) begin
      errors++;
      $display("FAIL R%0d: gate_hi=%b gate_lo=%b expected %b %b",
               req, gate_hi, gate_lo, exp_hi, exp_lo);
    end
    checks++;
    if ((gate_hi & gate_lo) != '0) begin
      errors++;
      $display("FAIL R10: gate_hi=%b gate_lo=%b both on, expected disjoint",
               gate_hi, gate_lo);
    end
  endtask

  // Called at a falling edge: apply inputs, pass one rising edge, back to fall.
  task automatic step(input logic inh, input logic [NLEG-1:0] h,
                      input logic [NLEG-1:0] l);
    inhibit = inh;
    cmd_hi  = h;
    cmd_lo  = l;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; inhibit = 1'b0; cmd_hi = '1; cmd_lo = '0;
    @(negedge clk);
    step(1'b0, '1, '0);
    check(1, '0, '0);                     // R1 gates off during reset
    rst = 1'b0;
    step(1'b0, '1, '0);
    check(1, '0, '0);                     // R1 first edge after reset
    step(1'b0, '1, '0);
    check(1, '0, '0);                     // R1 still counting
    step(1'b0, '1, '0);
    check(1, '1, '0);                     // R1 on after full delay
    step(1'b0, '0, '0);
    check(4, '0, '0);

    // Table walk on leg A, legs B and C idle (R9: stay off)
    for (int k = 0; k < NVEC; k++) begin
      step(VEC[k][4], {2'b00, VEC[k][3]}, {2'b00, VEC[k][2]});
      check(int'(VEC[k][8:5]), {2'b00, VEC[k][1]}, {2'b00, VEC[k][0]});
    end

    // R9: leg A overlapped, leg B high side, leg C low side
    for (int k = 0; k < DT; k++) begin
      step(1'b0, 3'b011, 3'b101);
      check(9, '0, '0);
    end
    step(1'b0, 3'b011, 3'b101);
    check(9, 3'b010, 3'b100);
    // R9: leg A drops low side, others undisturbed
    step(1'b0, 3'b011, 3'b100);
    check(9, 3'b010, 3'b100);
    step(1'b0, 3'b011, 3'b100);
    check(9, 3'b010, 3'b100);
    step(1'b0, 3'b011, 3'b100);
    check(6, 3'b011, 3'b100);

    // R1: reset in the middle of conduction
    rst = 1'b1;
    step(1'b0, 3'b011, 3'b100);
    check(1, '0, '0);
    rst = 1'b0;
    step(1'b0, '0, '0);
    check(1, '0, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule